// File: doc/BRIEF.md
# Analog Control Register Space

This block is a 64 KB memory-mapped register space for analog and power control. It is divided into address windows: a bank of PLL control registers starting at byte offset 0x60, a bank of power-management registers starting at byte offset 0x200, and a single read-only chip identification word at offset 0x800. A simple 32-bit register bus drives it. Each request carries a valid strobe, a write enable, a byte address and write data. The block answers one cycle later with read data and a flag that marks the access as ignored.

Each register in the two writable banks takes up a 16-byte slot, which gives four aliases per register. Address bits [3:2] choose how a write combines with the stored value: 0 = plain write, 1 = set bits, 2 = clear bits, 3 = toggle bits. A read at any of the four aliases returns the stored value. The identification word sits above every other window. If a bank is built large enough to cover offset 0x800, that word still wins at that exact address. The other aliases of the covered slot keep reaching the bank register.

Top module: `actl_regspace`

## Requirements
- R1: After a synchronous active-low reset, PLL register i holds 0x80002000 + i, so its lock bit (bit 31) reads 1. Every power-management register reads 0.
- R2: A read at offset 0x800 returns 0x00720010 with the ignored flag low.
- R3: A write at offset 0x800 changes nothing and raises the ignored flag in its response.
- R4: A write at slot offset +0x0 of a bank register replaces that register's value.
- R5: A write at slot offset +0x4 ORs the write data into the register.
- R6: A write at slot offset +0x8 clears the register bits that are set in the write data.
- R7: A write at slot offset +0xC XORs the write data into the register.
- R8: A read at any of a slot's four aliases returns the register value with the ignored flag low.
- R9: When the power-management window covers offset 0x800, the identification word takes priority there for reads and writes. Offsets 0x804, 0x808 and 0x80C still read and modify the covered bank register.
- R10: Any access that falls in no window, or whose address bits [1:0] are not zero, returns zero read data and raises the ignored flag. A write of this kind changes no register.
- R11: rsp_valid is high exactly one cycle after each cycle with req_valid high. A write to a mapped register responds with zero data and the flag low, and rsp_valid stays low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address inside the 64 KB space |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero for writes and ignored accesses |
| rsp_ign | output | 1 | Access hit no register or was refused |

## Verification
The bench keeps the default of nine PLL registers, whose window ends at 0xF0. It raises the power-management bank to 100 registers, so that window runs up to 0x840 and its slot 96 sits under the identification word. That overlap is what lets the bench check the priority rule. It also lets the bench confirm that a refused write at 0x800 left the covered register alone, by reading that register back through 0x804. Random traffic over all three windows, the gaps and misaligned addresses then exercises the four alias operations against a bench model.

// File: rtl/actl_pkg.sv
// Shared definitions for the analog control register space.
// Assumes 32-bit registers, each in a 16-byte slot with four write aliases.
package actl_pkg;

    // Alias operation chosen by address bits [3:2]
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } alias_op_e;

    localparam int unsigned SLOT_BYTES = 16;

    // Combine stored value and write data according to the alias operation
    function automatic logic [31:0] alias_apply(input logic [31:0] cur,
                                                input alias_op_e op,
                                                input logic [31:0] val);
        case (op)
            OP_WRITE:  return val;
            OP_SET:    return cur | val;
            OP_CLEAR:  return cur & ~val;
            default:   return cur ^ val;
        endcase
    endfunction

endpackage

// File: rtl/actl_decode.sv
// Window decoder: maps a byte address to at most one target
// (ID word, PLL bank, power bank). The ID word has top priority,
// then the PLL bank, then the power bank.
// Assumes bank bases are 16-byte aligned and both banks hold >= 2 registers.
module actl_decode #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned PLL_BASE = 32'h60,
    parameter int unsigned PLL_REGS = 9,
    parameter int unsigned PMU_BASE = 32'h200,
    parameter int unsigned PMU_REGS = 16,
    parameter int unsigned ID_OFF   = 32'h800,
    parameter int unsigned IDX_W    = 7
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit_id,
    output logic                hit_pll,
    output logic                hit_pmu,
    output logic [IDX_W-1:0]    idx,
    output actl_pkg::alias_op_e op
);
    import actl_pkg::*;

    localparam int unsigned PLL_END = PLL_BASE + PLL_REGS * SLOT_BYTES;
    localparam int unsigned PMU_END = PMU_BASE + PMU_REGS * SLOT_BYTES;

    logic [31:0] a32, pll_off, pmu_off;
    logic        aligned, in_pll, in_pmu;

    // Range tests and window selection with priority
    always_comb begin
        a32     = 32'(addr);
        pll_off = a32 - PLL_BASE;
        pmu_off = a32 - PMU_BASE;
        aligned = (addr[1:0] == 2'b00);
        in_pll  = (a32 >= PLL_BASE) && (a32 < PLL_END);
        in_pmu  = (a32 >= PMU_BASE) && (a32 < PMU_END);
        hit_id  = aligned && (a32 == ID_OFF);
        hit_pll = aligned && !hit_id && in_pll;
        hit_pmu = aligned && !hit_id && !in_pll && in_pmu;
        idx     = hit_pll ? pll_off[IDX_W+3:4] : pmu_off[IDX_W+3:4];
        op      = alias_op_e'(addr[3:2]);
    end

    // R9: priority leaves at most one window selected
    always_comb begin
        if (!$isunknown(addr))
            a_r9_single_window: assert ($onehot0({hit_id, hit_pll, hit_pmu}));
    end

endmodule

// File: rtl/actl_bank.sv
// Bank of 32-bit registers updated through set/clear/toggle aliases.
// LOCK_RESET picks the reset image: 1 = PLL image (base + index, bit 31
// set), 0 = all zero. Reads are combinational from rd_idx.
module actl_bank #(
    parameter int unsigned NREGS      = 9,
    parameter int unsigned IDX_W      = 7,
    parameter bit          LOCK_RESET = 1'b1,
    parameter logic [31:0] DEF_BASE   = 32'h2000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  actl_pkg::alias_op_e wr_op,
    input  logic [31:0]         wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [31:0]         rd_data
);
    import actl_pkg::*;

    logic [31:0] regs [NREGS];

    // Reset image of register i
    function automatic logic [31:0] reset_val(input int unsigned i);
        if (LOCK_RESET) return 32'h8000_0000 | (DEF_BASE + 32'(i));
        else            return 32'h0;
    endfunction

    // Load reset image or apply the alias write to the addressed register
    always_ff @(posedge clk) begin
        for (int unsigned i = 0; i < NREGS; i++) begin
            if (!rst_n)
                regs[i] <= reset_val(i);
            else if (wr_en && (32'(wr_idx) == i))
                regs[i] <= alias_apply(regs[i], wr_op, wr_data);
        end
    end

    // Read mux, zero outside the bank
    always_comb begin
        rd_data = '0;
        if (32'(rd_idx) < NREGS) rd_data = regs[rd_idx];
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_chk
        // R10: a register not addressed by a write keeps its value
        a_r10_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (32'(wr_idx) == g)) |=> $stable(regs[g]));
        if (LOCK_RESET) begin : g_lock
            // R1: PLL registers leave reset with the lock bit high
            a_r1_lock_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> regs[g][31]);
        end else begin : g_zero
            // R1: power registers leave reset cleared
            a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> (regs[g] == 32'h0));
        end
    end

endmodule

// File: rtl/actl_regspace.sv
// Top of the analog control register space. Decodes the request, routes
// writes to the PLL or power bank, serves the read-only ID word and
// registers the response one cycle after the request.
// Assumes at most one request per cycle; no back-pressure.
module actl_regspace #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned PLL_REGS = 9,
    parameter int unsigned PMU_REGS = 16,
    parameter int unsigned PLL_BASE = 32'h60,
    parameter int unsigned PMU_BASE = 32'h200,
    parameter int unsigned ID_OFF   = 32'h800,
    parameter logic [31:0] ID_VALUE = 32'h0072_0010,
    parameter logic [31:0] PLL_DEF  = 32'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_ign
);
    import actl_pkg::*;

    localparam int unsigned MAX_REGS = (PLL_REGS > PMU_REGS) ? PLL_REGS : PMU_REGS;
    localparam int unsigned IDX_W    = $clog2(MAX_REGS);

    logic             hit_id, hit_pll, hit_pmu, hit_any;
    logic [IDX_W-1:0] idx;
    alias_op_e        op;
    logic [31:0]      pll_rd, pmu_rd, rd_sel;

    actl_decode #(
        .ADDR_W(ADDR_W), .PLL_BASE(PLL_BASE), .PLL_REGS(PLL_REGS),
        .PMU_BASE(PMU_BASE), .PMU_REGS(PMU_REGS), .ID_OFF(ID_OFF), .IDX_W(IDX_W)
    ) u_dec (
        .addr(req_addr), .hit_id(hit_id), .hit_pll(hit_pll),
        .hit_pmu(hit_pmu), .idx(idx), .op(op)
    );

    actl_bank #(.NREGS(PLL_REGS), .IDX_W(IDX_W), .LOCK_RESET(1'b1), .DEF_BASE(PLL_DEF)) u_pll (
        .clk(clk), .rst_n(rst_n),
        .wr_en(req_valid && req_we && hit_pll), .wr_idx(idx), .wr_op(op),
        .wr_data(req_wdata), .rd_idx(idx), .rd_data(pll_rd)
    );

    actl_bank #(.NREGS(PMU_REGS), .IDX_W(IDX_W), .LOCK_RESET(1'b0), .DEF_BASE(32'h0)) u_pmu (
        .clk(clk), .rst_n(rst_n),
        .wr_en(req_valid && req_we && hit_pmu), .wr_idx(idx), .wr_op(op),
        .wr_data(req_wdata), .rd_idx(idx), .rd_data(pmu_rd)
    );

    // Select read source by window
    always_comb begin
        hit_any = hit_id || hit_pll || hit_pmu;
        if (hit_id)       rd_sel = ID_VALUE;
        else if (hit_pll) rd_sel = pll_rd;
        else if (hit_pmu) rd_sel = pmu_rd;
        else              rd_sel = 32'h0;
    end

    // Register the response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= 32'h0;
            rsp_ign   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_we && hit_any) ? rd_sel : 32'h0;
            rsp_ign   <= req_valid && (!hit_any || (hit_id && req_we));
        end
    end

    // R11: response strobe follows the request strobe by one cycle
    a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2: ID read returns the fixed identification value
    a_r2_id_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && (32'(req_addr) == ID_OFF)) |=> (rsp_rdata == ID_VALUE && !rsp_ign));
    // R3: ID write is refused
    a_r3_id_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && (32'(req_addr) == ID_OFF)) |=> rsp_ign);
    // R10: ignored responses carry zero data
    a_r10_ign_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ign |-> (rsp_rdata == 32'h0));

endmodule

// File: tb/tb_actl_regspace.sv
module tb_actl_regspace;

    localparam int unsigned NPLL    = 9;
    localparam int unsigned NPMU    = 100;
    localparam int unsigned PLLB    = 32'h60;
    localparam int unsigned PMUB    = 32'h200;
    localparam int unsigned IDOFF   = 32'h800;
    localparam logic [31:0] IDVAL   = 32'h0072_0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [31:0] req_wdata = 32'h0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_ign;

    int checks = 0;
    int failures = 0;

    logic [31:0] pll_m [NPLL];
    logic [31:0] pmu_m [NPMU];

    actl_regspace #(.PLL_REGS(NPLL), .PMU_REGS(NPMU)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_ign(rsp_ign)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] apply(input logic [31:0] cur, input logic [1:0] op, input logic [31:0] v);
        case (op)
            2'd0: return v;
            2'd1: return cur | v;
            2'd2: return cur & ~v;
            default: return cur ^ v;
        endcase
    endfunction

    // Reference model: updates model state and returns expected response
    task automatic model(input logic we, input logic [15:0] a, input logic [31:0] d,
                         output logic [31:0] ed, output logic ei);
        int unsigned ai = 32'(a);
        int unsigned ix;
        ed = 32'h0; ei = 1'b0;
        if (a[1:0] != 2'b00) ei = 1'b1;
        else if (ai == IDOFF) begin
            if (we) ei = 1'b1; else ed = IDVAL;
        end else if (ai >= PLLB && ai < PLLB + NPLL*16) begin
            ix = (ai - PLLB) / 16;
            if (we) pll_m[ix] = apply(pll_m[ix], a[3:2], d); else ed = pll_m[ix];
        end else if (ai >= PMUB && ai < PMUB + NPMU*16) begin
            ix = (ai - PMUB) / 16;
            if (we) pmu_m[ix] = apply(pmu_m[ix], a[3:2], d); else ed = pmu_m[ix];
        end else ei = 1'b1;
    endtask

    task automatic acc(input logic we, input logic [15:0] a, input logic [31:0] d, input string tag);
        logic [31:0] ed;
        logic        ei;
        model(we, a, d, ed, ei);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1 && rsp_rdata === ed && rsp_ign === ei, tag,
              {rsp_valid, rsp_ign, rsp_rdata}, {1'b1, ei, ed});
    endtask

    function automatic logic [15:0] pll_addr(input int unsigned i, input int unsigned al);
        return 16'(PLLB + i*16 + al*4);
    endfunction

    function automatic logic [15:0] pmu_addr(input int unsigned i, input int unsigned al);
        return 16'(PMUB + i*16 + al*4);
    endfunction

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R11 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NPLL; i++) pll_m[i] = 32'h8000_2000 + 32'(i);
        for (int i = 0; i < NPMU; i++) pmu_m[i] = 32'h0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(rsp_valid === 1'b0, "R11 no response in reset", {33'h0, rsp_valid}, 34'h0);
        rst_n = 1'b1;

        // R1: reset images via plain reads
        for (int i = 0; i < NPLL; i++) acc(1'b0, pll_addr(i, 0), 32'h0, "R1 PLL reset image");
        for (int i = 0; i < NPMU; i += 7) acc(1'b0, pmu_addr(i, 0), 32'h0, "R1 power reset zero");

        // R2, R3, R9: ID word and the slot it covers
        acc(1'b0, 16'h0800, 32'h0, "R2 ID read");
        acc(1'b1, 16'h0804, 32'h0000_00F0, "R9 set via covered slot alias");
        acc(1'b1, 16'h0800, 32'hFFFF_FFFF, "R3 ID write refused");
        acc(1'b0, 16'h0800, 32'h0, "R3 ID unchanged after write");
        acc(1'b0, 16'h0804, 32'h0, "R9 covered register untouched by ID write");
        acc(1'b1, 16'h080C, 32'h0000_0011, "R9 toggle via covered slot");
        acc(1'b0, 16'h0808, 32'h0, "R9 covered register read");

        // R4-R8: alias operations on both banks
        acc(1'b1, pll_addr(3, 0), 32'h1234_5678, "R4 plain write");
        acc(1'b0, pll_addr(3, 0), 32'h0, "R4 readback");
        acc(1'b1, pll_addr(3, 1), 32'h8000_000F, "R5 set");
        acc(1'b0, pll_addr(3, 1), 32'h0, "R8 read at set alias");
        acc(1'b1, pll_addr(3, 2), 32'h1200_0003, "R6 clear");
        acc(1'b0, pll_addr(3, 2), 32'h0, "R8 read at clear alias");
        acc(1'b1, pll_addr(3, 3), 32'hFFFF_0000, "R7 toggle");
        acc(1'b0, pll_addr(3, 3), 32'h0, "R8 read at toggle alias");
        acc(1'b1, pmu_addr(NPMU-1, 1), 32'hA5A5_0000, "R5 set last power reg");
        acc(1'b0, pmu_addr(NPMU-1, 0), 32'h0, "R5 readback last power reg");
        acc(1'b1, pll_addr(NPLL-1, 2), 32'h8000_0000, "R6 clear lock bit");
        acc(1'b0, pll_addr(NPLL-1, 0), 32'h0, "R6 readback");

        // R10: unmapped and misaligned
        acc(1'b0, 16'h0000, 32'h0, "R10 below first window");
        acc(1'b0, 16'h005C, 32'h0, "R10 just below PLL bank");
        acc(1'b0, pll_addr(NPLL, 0), 32'h0, "R10 just past PLL bank");
        acc(1'b1, 16'h5000, 32'hDEAD_BEEF, "R10 unmapped write");
        acc(1'b0, 16'hFFFC, 32'h0, "R10 top of space");
        acc(1'b1, pll_addr(2, 0) + 16'd1, 32'hFFFF_FFFF, "R10 misaligned write");
        acc(1'b0, pll_addr(2, 0), 32'h0, "R10 register untouched by misaligned write");
        acc(1'b0, 16'h0802, 32'h0, "R10 misaligned ID read");

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int unsigned kind = $urandom_range(0, 9);
            logic        we = 1'($urandom_range(0, 1));
            logic [31:0] d = $urandom;
            logic [15:0] a;
            string       tag;
            if (kind < 4) begin
                a = pll_addr($urandom_range(0, NPLL-1), $urandom_range(0, 3));
                tag = we ? "R4 R5 R6 R7 random PLL write" : "R8 random PLL read";
            end else if (kind < 8) begin
                a = pmu_addr($urandom_range(0, NPMU-1), $urandom_range(0, 3));
                tag = we ? "R4 R5 R6 R7 random power write" : "R8 random power read";
            end else if (kind == 8) begin
                a = 16'h0800;
                tag = we ? "R3 random ID write" : "R2 random ID read";
            end else begin
                a = 16'($urandom);
                tag = "R10 random address";
            end
            acc(we, a, d, tag);
        end

        // Final sweep of all state
        for (int i = 0; i < NPLL; i++) acc(1'b0, pll_addr(i, 0), 32'h0, "R8 final PLL sweep");
        for (int i = 0; i < NPMU; i++) acc(1'b0, pmu_addr(i, 1), 32'h0, "R8 final power sweep");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule